// File: doc/BRIEF.md
# Flash Write Operation Decoder

This block sits between the CPU bus and a flash array controller and turns each CPU write aimed at flash into one of four outcomes. The write is rejected, or it becomes a word program, a 1024-byte page erase, or a whole-block erase. The outcome depends on three mutually exclusive mode bits in a control register. A second register holds one write-enable bit for each 512-byte section of the data block. After reset both registers are zero, so every section is write-protected and no mode is active.

The block exposes the array command as a one-cycle `cmd_valid` strobe. The strobe carries an operation code, an aligned target address, a flag that tells the array to erase the associated main block as well, and a flag that asks for automatic verification. A CPU write that cannot be honoured raises a one-cycle protection fault. A control-register write that would leave more than one mode active, or that would change a busy-guarded bit while the array is busy, is dropped and raises a one-cycle configuration error. An interrupt pulse marks the moment the write buffer stops being full. The array itself is represented only by the `array_busy` and `buf_full` inputs.

Address map, in bytes:
- Program main block: 0x000000 to 0x03FFFF.
- Program information block: 0x0F0000 to 0x0F03FF. It belongs to the program main block.
- Data block: 0x0E0000 to 0x0E1FFF, split into 16 sections.

Top module: `flash_wr_decoder`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears the control register and the section-enable register to zero. In the cycle after reset, `cmd_valid`, `prot_fault`, `cfg_err` and `irq` are low.
- R2: Section-enable bit n allows CPU writes to data-block bytes 0x0E0000+n*0x200 through 0x0E0000+n*0x200+0x1FF. A write to a section whose bit is 0 issues no command and raises `prot_fault`.
- R3: While control bit 1 (CPU write disable) is set, every CPU write issues no command and raises `prot_fault`.
- R4: With control bit 5 (program) set, an accepted write produces `cmd_valid` with `cmd_op`=1 in the next cycle. `cmd_addr` is the write address with bit 0 cleared. `cmd_verify` is the inverse of control bit 3 (verify disable).
- R5: With control bit 6 (page erase) set, an accepted write produces `cmd_op`=2 with `cmd_addr` aligned down to 1024 bytes. A write to the information block is ignored: it issues no command and raises no fault.
- R6: With control bit 7 (module erase) set, an accepted write produces `cmd_op`=3 with `cmd_addr` at the base of the addressed block. `cmd_with_main` is 1 only when the write targets the information block.
- R7: A control write with more than one of bits 7..5 set leaves the control register unchanged and pulses `cfg_err` in the next cycle.
- R8: While `array_busy` is high, a control write that changes any of bits 0, 1, 3, 5, 6 or 7 is dropped and pulses `cfg_err`. A write that changes only bit 4 is accepted.
- R9: A CPU write with no mode bit set, with an address outside all three regions, or while `array_busy` is high, issues no command and raises `prot_fault`. `cmd_valid` and `prot_fault` are never high together.
- R10: When control bit 4 is set, `irq` pulses for one cycle in the cycle after `buf_full` is first seen low following a high sample. When bit 4 is clear, `irq` stays low.
- R11: Control bit 2 is reserved and always reads 0. `low_power` follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the section-enable register |
| reg_wdata | input | 16 | Register write data (the control register takes bits 7..0) |
| ctrl_q | output | 8 | Current control register |
| sect_we_q | output | 16 | Current section-enable register |
| low_power | output | 1 | Low-power read mode request |
| cpu_wr | input | 1 | CPU write to flash space |
| cpu_addr | input | 24 | Byte address of the CPU write |
| array_busy | input | 1 | Array is programming or erasing |
| buf_full | input | 1 | Array write buffer is full |
| cmd_valid | output | 1 | One-cycle array command strobe |
| cmd_op | output | 2 | 0 none, 1 program, 2 page erase, 3 block erase |
| cmd_addr | output | 24 | Aligned command address (0 when no command) |
| cmd_with_main | output | 1 | Erase also covers the associated main block |
| cmd_verify | output | 1 | Verify the programmed word |
| prot_fault | output | 1 | One-cycle pulse: CPU write rejected |
| cfg_err | output | 1 | One-cycle pulse: control write dropped |
| irq | output | 1 | One-cycle buffer-free interrupt |

## Verification
The assertions assume that `rst` is high at the first clock edge, so no property ever samples the registers before they have been cleared. They also assume that `reg_wr` and `cpu_wr` are single-cycle strobes driven away from the clock edge. The bench drives every strobe on the falling edge for exactly one rising edge. It changes `array_busy` and `buf_full` only on falling edges, and it keeps each address inside or clearly outside the three regions listed above.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_PAGE  = 2'd2,
    OP_BLOCK = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_PMAIN = 2'd1,
    RG_PINFO = 2'd2,
    RG_DATA  = 2'd3
  } region_e;

  localparam int CB_LP   = 0;
  localparam int CB_CWD  = 1;
  localparam int CB_RSV  = 2;
  localparam int CB_NOVF = 3;
  localparam int CB_IEN  = 4;
  localparam int CB_PE   = 5;
  localparam int CB_PER  = 6;
  localparam int CB_MER  = 7;

  localparam logic [7:0] BUSY_GUARD = 8'b1110_1011;

endpackage

// File: rtl/fwd_cfg_regs.sv
module fwd_cfg_regs
  import flash_dec_pkg::*;
#(
  parameter int SEC_NUM = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [SEC_NUM-1:0] reg_wdata,
  input  logic               array_busy,
  output logic [7:0]         ctrl_q,
  output logic [SEC_NUM-1:0] sect_we_q,
  output logic               cfg_err
);

  logic [7:0] new_ctrl;
  logic       multi_mode;
  logic       busy_clash;
  logic       reject;

  always_comb begin
    new_ctrl         = reg_wdata[7:0];
    new_ctrl[CB_RSV] = 1'b0;
    multi_mode       = $countones(new_ctrl[CB_MER:CB_PE]) > 1;
    busy_clash       = array_busy && (((new_ctrl ^ ctrl_q) & BUSY_GUARD) != 8'h00);
    reject           = multi_mode || busy_clash;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      sect_we_q <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      if (reg_wr && !reg_sel) begin
        if (reject) cfg_err <= 1'b1;
        else        ctrl_q  <= new_ctrl;
      end
      if (reg_wr && reg_sel) sect_we_q <= reg_wdata;
    end
  end

endmodule

// File: rtl/fwd_addr_class.sv
module fwd_addr_class
  import flash_dec_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          SEC_NUM     = 16,
  parameter int unsigned SEC_BYTES   = 512,
  parameter int unsigned DATA_BASE   = 'h0E0000,
  parameter int unsigned PMAIN_BASE  = 'h000000,
  parameter int unsigned PMAIN_BYTES = 'h40000,
  parameter int unsigned INFO_BASE   = 'h0F0000,
  parameter int unsigned INFO_BYTES  = 'h400
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEC_NUM-1:0] sect_we,
  output region_e           region,
  output logic [ADDR_W-1:0] region_base,
  output logic              sect_ok
);

  localparam int unsigned DATA_BYTES = SEC_NUM * SEC_BYTES;
  localparam logic [ADDR_W-1:0] DATA_LO  = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] PMAIN_LO = ADDR_W'(PMAIN_BASE);
  localparam logic [ADDR_W-1:0] INFO_LO  = ADDR_W'(INFO_BASE);

  logic [SEC_NUM-1:0] sec_hit;
  logic in_data, in_pmain, in_info;

  for (genvar n = 0; n < SEC_NUM; n++) begin : g_sec
    localparam logic [ADDR_W-1:0] SEC_LO = ADDR_W'(DATA_BASE + n * SEC_BYTES);
    assign sec_hit[n] = (addr - SEC_LO) < ADDR_W'(SEC_BYTES);
  end

  always_comb begin
    in_data  = (addr - DATA_LO)  < ADDR_W'(DATA_BYTES);
    in_pmain = (addr - PMAIN_LO) < ADDR_W'(PMAIN_BYTES);
    in_info  = (addr - INFO_LO)  < ADDR_W'(INFO_BYTES);
    sect_ok  = |(sec_hit & sect_we);
    if (in_data) begin
      region      = RG_DATA;
      region_base = DATA_LO;
    end else if (in_pmain) begin
      region      = RG_PMAIN;
      region_base = PMAIN_LO;
    end else if (in_info) begin
      region      = RG_PINFO;
      region_base = INFO_LO;
    end else begin
      region      = RG_NONE;
      region_base = '0;
    end
  end

endmodule

// File: rtl/fwd_cmd_gen.sv
module fwd_cmd_gen
  import flash_dec_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int unsigned PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  region_e           region,
  input  logic [ADDR_W-1:0] region_base,
  input  logic              sect_ok,
  input  logic              array_busy,
  input  logic              m_cwd,
  input  logic              m_novf,
  input  logic              m_pe,
  input  logic              m_per,
  input  logic              m_mer,
  output logic              cmd_valid,
  output fop_e              cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_with_main,
  output logic              cmd_verify,
  output logic              prot_fault
);

  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);

  fop_e              n_op;
  logic [ADDR_W-1:0] n_addr;
  logic              n_main, n_fault, allowed;

  always_comb begin
    n_op    = OP_NONE;
    n_addr  = '0;
    n_main  = 1'b0;
    n_fault = 1'b0;
    allowed = !m_cwd && !array_busy && (region != RG_NONE) &&
              ((region != RG_DATA) || sect_ok);
    if (cpu_wr) begin
      if (!allowed) begin
        n_fault = 1'b1;
      end else if (m_pe) begin
        n_op   = OP_PROG;
        n_addr = cpu_addr & WORD_MASK;
      end else if (m_per) begin
        if (region != RG_PINFO) begin
          n_op   = OP_PAGE;
          n_addr = cpu_addr & PAGE_MASK;
        end
      end else if (m_mer) begin
        n_op   = OP_BLOCK;
        n_addr = region_base;
        n_main = (region == RG_PINFO);
      end else begin
        n_fault = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid     <= 1'b0;
      cmd_op        <= OP_NONE;
      cmd_addr      <= '0;
      cmd_with_main <= 1'b0;
      cmd_verify    <= 1'b0;
      prot_fault    <= 1'b0;
    end else begin
      cmd_valid     <= (n_op != OP_NONE);
      cmd_op        <= n_op;
      cmd_addr      <= n_addr;
      cmd_with_main <= n_main;
      cmd_verify    <= (n_op == OP_PROG) && !m_novf;
      prot_fault    <= n_fault;
    end
  end

endmodule

// File: rtl/fwd_irq_gen.sv
module fwd_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic ien,
  input  logic buf_full,
  output logic irq
);

  logic full_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_d <= 1'b0;
      irq    <= 1'b0;
    end else begin
      full_d <= buf_full;
      irq    <= ien && full_d && !buf_full;
    end
  end

endmodule

// File: rtl/flash_wr_decoder.sv
module flash_wr_decoder
  import flash_dec_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          SEC_NUM     = 16,
  parameter int unsigned SEC_BYTES   = 512,
  parameter int unsigned PAGE_BYTES  = 1024,
  parameter int unsigned DATA_BASE   = 'h0E0000,
  parameter int unsigned PMAIN_BASE  = 'h000000,
  parameter int unsigned PMAIN_BYTES = 'h40000,
  parameter int unsigned INFO_BASE   = 'h0F0000,
  parameter int unsigned INFO_BYTES  = 'h400
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [SEC_NUM-1:0] reg_wdata,
  output logic [7:0]         ctrl_q,
  output logic [SEC_NUM-1:0] sect_we_q,
  output logic               low_power,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               array_busy,
  input  logic               buf_full,
  output logic               cmd_valid,
  output logic [1:0]         cmd_op,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic               cmd_with_main,
  output logic               cmd_verify,
  output logic               prot_fault,
  output logic               cfg_err,
  output logic               irq
);

  region_e           region;
  logic [ADDR_W-1:0] region_base;
  logic              sect_ok;
  fop_e              op_q;

  fwd_cfg_regs #(.SEC_NUM(SEC_NUM)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .array_busy(array_busy),
    .ctrl_q(ctrl_q), .sect_we_q(sect_we_q), .cfg_err(cfg_err)
  );

  fwd_addr_class #(
    .ADDR_W(ADDR_W), .SEC_NUM(SEC_NUM), .SEC_BYTES(SEC_BYTES),
    .DATA_BASE(DATA_BASE), .PMAIN_BASE(PMAIN_BASE), .PMAIN_BYTES(PMAIN_BYTES),
    .INFO_BASE(INFO_BASE), .INFO_BYTES(INFO_BYTES)
  ) u_class (
    .addr(cpu_addr), .sect_we(sect_we_q),
    .region(region), .region_base(region_base), .sect_ok(sect_ok)
  );

  fwd_cmd_gen #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_cmd (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .region(region), .region_base(region_base), .sect_ok(sect_ok),
    .array_busy(array_busy),
    .m_cwd(ctrl_q[CB_CWD]), .m_novf(ctrl_q[CB_NOVF]), .m_pe(ctrl_q[CB_PE]),
    .m_per(ctrl_q[CB_PER]), .m_mer(ctrl_q[CB_MER]),
    .cmd_valid(cmd_valid), .cmd_op(op_q), .cmd_addr(cmd_addr),
    .cmd_with_main(cmd_with_main), .cmd_verify(cmd_verify),
    .prot_fault(prot_fault)
  );

  fwd_irq_gen u_irq (
    .clk(clk), .rst(rst), .ien(ctrl_q[CB_IEN]), .buf_full(buf_full), .irq(irq)
  );

  assign cmd_op    = op_q;
  assign low_power = ctrl_q[CB_LP];

endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int SEC_NUM = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         ctrl_q,
  input logic [SEC_NUM-1:0] sect_we_q,
  input logic               cpu_wr,
  input logic               array_busy,
  input logic               buf_full,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic               cmd_with_main,
  input logic               prot_fault,
  input logic               cfg_err,
  input logic               irq
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == 8'h00) && (sect_we_q == '0) && !cmd_valid && !irq);

  a_r3_cwd_blocks: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(ctrl_q[1]));

  a_r4_prog_needs_mode: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |-> $past(ctrl_q[5]));

  a_r6_main_only_block: assert property (@(posedge clk) disable iff (rst)
    cmd_with_main |-> (cmd_valid && cmd_op == 2'd3));

  a_r7_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_q[7:5]));

  a_r7_err_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $stable(ctrl_q));

  a_r9_fault_xor_cmd: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && prot_fault));

  a_r9_cmd_needs_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(cpu_wr) && !$past(array_busy)));

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ctrl_q[4]) && !$past(buf_full)));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[2]);

endmodule

bind flash_wr_decoder fwd_checker #(.SEC_NUM(SEC_NUM)) u_fwd_chk (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .sect_we_q(sect_we_q),
  .cpu_wr(cpu_wr), .array_busy(array_busy), .buf_full(buf_full),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_with_main(cmd_with_main),
  .prot_fault(prot_fault), .cfg_err(cfg_err), .irq(irq)
);

// File: tb/test_flash_wr_decoder.sv
`timescale 1ns/1ps
module test_flash_wr_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  ctrl_q;
  logic [15:0] sect_we_q;
  logic        low_power;
  logic        cpu_wr = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        array_busy = 1'b0, buf_full = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic        cmd_with_main, cmd_verify, prot_fault, cfg_err, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_wr_decoder i_flash_wr_decoder (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .sect_we_q(sect_we_q),
    .low_power(low_power), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .array_busy(array_busy), .buf_full(buf_full), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_with_main(cmd_with_main),
    .cmd_verify(cmd_verify), .prot_fault(prot_fault), .cfg_err(cfg_err),
    .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] sec;
    logic [23:0] addr;
    logic [1:0]  op;
    logic [23:0] eaddr;
    logic        emain;
    logic        ever;
    logic        efault;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 16'h0000, 24'h001235, 2'd1, 24'h001234, 1'b0, 1'b1, 1'b0},
    '{8'h20, 16'h0000, 24'h0E0203, 2'd0, 24'h000000, 1'b0, 1'b0, 1'b1},
    '{8'h20, 16'h0002, 24'h0E0203, 2'd1, 24'h0E0202, 1'b0, 1'b1, 1'b0},
    '{8'h20, 16'h8000, 24'h0E1FFE, 2'd1, 24'h0E1FFE, 1'b0, 1'b1, 1'b0},
    '{8'h20, 16'h8000, 24'h0E1DFE, 2'd0, 24'h000000, 1'b0, 1'b0, 1'b1},
    '{8'h40, 16'h0000, 24'h012345, 2'd2, 24'h012000, 1'b0, 1'b0, 1'b0},
    '{8'h40, 16'h0000, 24'h0F0010, 2'd0, 24'h000000, 1'b0, 1'b0, 1'b0},
    '{8'h80, 16'h0000, 24'h023456, 2'd3, 24'h000000, 1'b0, 1'b0, 1'b0},
    '{8'h80, 16'h0000, 24'h0F0020, 2'd3, 24'h0F0000, 1'b1, 1'b0, 1'b0},
    '{8'h80, 16'h0001, 24'h0E0100, 2'd3, 24'h0E0000, 1'b0, 1'b0, 1'b0},
    '{8'h00, 16'hFFFF, 24'h001000, 2'd0, 24'h000000, 1'b0, 1'b0, 1'b1},
    '{8'h22, 16'hFFFF, 24'h001000, 2'd0, 24'h000000, 1'b0, 1'b0, 1'b1},
    '{8'h20, 16'hFFFF, 24'h050000, 2'd0, 24'h000000, 1'b0, 1'b0, 1'b1},
    '{8'h40, 16'h0001, 24'h0E01FE, 2'd2, 24'h0E0000, 1'b0, 1'b0, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      1, 2, 3, 4: return "R2";
      5, 6, 13:   return "R5";
      7, 8, 9:    return "R6";
      11:         return "R3";
      10, 12:     return "R9";
      default:    return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic sel, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic cpu_write(logic [23:0] a);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_q), 0);
    chk("R1 sect", 32'(sect_we_q), 0);
    chk("R1 outs", {28'd0, cmd_valid, prot_fault, cfg_err, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, {8'h00, VECS[i].ctrl});
      wr_reg(1'b1, VECS[i].sec);
      cpu_write(VECS[i].addr);
      chk({vtag(i), " valid"}, 32'(cmd_valid), 32'(VECS[i].op != 2'd0));
      chk({vtag(i), " op"},    32'(cmd_op), 32'(VECS[i].op));
      chk({vtag(i), " addr"},  32'(cmd_addr), 32'(VECS[i].eaddr));
      chk({vtag(i), " main"},  32'(cmd_with_main), 32'(VECS[i].emain));
      chk({vtag(i), " verify"}, 32'(cmd_verify), 32'(VECS[i].ever));
      chk({vtag(i), " fault"}, 32'(prot_fault), 32'(VECS[i].efault));
    end

    // R4 verify disabled (bit 3)
    wr_reg(1'b0, 16'h0028);
    cpu_write(24'h000100);
    chk("R4 novf valid", 32'(cmd_valid), 1);
    chk("R4 novf verify", 32'(cmd_verify), 0);

    // R7 two mode bits
    wr_reg(1'b0, 16'h0020);
    wr_reg(1'b0, 16'h0060);
    chk("R7 err", 32'(cfg_err), 1);
    chk("R7 ctrl kept", 32'(ctrl_q), 32'h20);
    @(posedge clk); #1;
    chk("R7 err pulse", 32'(cfg_err), 0);

    // R8 busy guard
    @(negedge clk); array_busy = 1'b1;
    wr_reg(1'b0, 16'h0040);
    chk("R8 mode blocked err", 32'(cfg_err), 1);
    chk("R8 mode blocked", 32'(ctrl_q), 32'h20);
    wr_reg(1'b0, 16'h0021);
    chk("R8 lp blocked", 32'(ctrl_q), 32'h20);
    wr_reg(1'b0, 16'h0030);
    chk("R8 ien ok err", 32'(cfg_err), 0);
    chk("R8 ien ok", 32'(ctrl_q), 32'h30);
    // R9 write while busy
    cpu_write(24'h000200);
    chk("R9 busy fault", 32'(prot_fault), 1);
    chk("R9 busy nocmd", 32'(cmd_valid), 0);
    @(negedge clk); array_busy = 1'b0;

    // R11 reserved bit and low power
    wr_reg(1'b0, 16'h0025);
    chk("R11 rsv", 32'(ctrl_q), 32'h21);
    chk("R11 lp", 32'(low_power), 1);

    // R10 interrupt enabled
    wr_reg(1'b0, 16'h0010);
    @(negedge clk); buf_full = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); buf_full = 1'b0;
    @(posedge clk); #1;
    chk("R10 irq", 32'(irq), 1);
    @(posedge clk); #1;
    chk("R10 irq pulse", 32'(irq), 0);
    // R10 interrupt disabled
    wr_reg(1'b0, 16'h0000);
    @(negedge clk); buf_full = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); buf_full = 1'b0;
    @(posedge clk); #1;
    chk("R10 no irq", 32'(irq), 0);
    @(posedge clk); #1;
    chk("R10 no irq late", 32'(irq), 0);

    // R1 reset mid-run
    wr_reg(1'b0, 16'h0080);
    wr_reg(1'b1, 16'h1234);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 ctrl again", 32'(ctrl_q), 0);
    chk("R1 sect again", 32'(sect_we_q), 0);
    // R2 everything protected after reset
    wr_reg(1'b0, 16'h0020);
    cpu_write(24'h0E0000);
    chk("R2 protected after reset", 32'(prot_fault), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule